// File: doc/BRIEF.md
# Programmable Periodic Rate Divider

This block takes a 32.768 kHz time base as its clock and derives from it a square wave and a sticky periodic flag. A 4-bit rate code picks the rate. Codes 3 to 15 run through a binary ladder from 8.192 kHz down to 2 Hz. Codes 1 and 2 are aliases for the 256 Hz and 128 Hz rates of codes 8 and 9. Code 0 stops both outputs. A single free-running 15-bit counter supplies every rate, and the rate code only chooses which counter bit drives the outputs.

The periodic flag sets on each rising edge of the selected wave. It stays set until a clear strobe removes it. A new rate code does not act at once while a rate is running. It is adopted at the next edge, rising or falling, of the wave that is currently selected, and the counter is never restarted. An enable input gates the square-wave pin. The flag runs whether the pin is enabled or not.

All pins are plain control and status signals. The block has no data stream and therefore no valid/ready handshake.

Top module: `periodic_rate_div`

## Requirements
- R1: With rate code 0 in force, `sqw_out` stays low and `pf_flag` never sets.
- R2: Codes 3 to 7 give a period of 2^(code-1) clock cycles: 4, 8, 16, 32 and 64 cycles.
- R3: Codes 8 to 15 give a period of 2^(code-1) clock cycles, from 128 up to 16384 cycles.
- R4: Code 1 gives a period of 128 cycles and code 2 gives 256 cycles, the same as codes 8 and 9.
- R5: The square wave has 50% duty: it is high for half a period and low for half. `pf_flag` sets on the same clock edge on which the wave rises.
- R6: While `sqw_en` is low, `sqw_out` stays low and `pf_flag` keeps setting once per period.
- R7: `pf_flag` stays high until a cycle in which `pf_clr` is high. It is low one cycle after that strobe, unless a new rising edge arrives on the same edge.
- R8: When a rising edge and `pf_clr` arrive on the same clock edge, the set wins. With `pf_clr` held high, the flag is high for exactly one cycle per period.
- R9: While a rate is running, a new code takes effect on the next edge of the current wave, and the counter keeps its phase. Example: the code changes from 15 to 3 just after a rising edge of code 15. The next flag then sets 8194 cycles after that edge. This is 8192 cycles to the falling edge plus 2 cycles to the first rising edge of code 3.
- R10: During and right after the active-low reset `rst_n`, `sqw_out` and `pf_flag` are low. The counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 4 | Requested rate code |
| sqw_en | input | 1 | Gates the square wave onto `sqw_out` |
| pf_clr | input | 1 | Clears the periodic flag (one-cycle strobe) |
| sqw_out | output | 1 | Gated square wave |
| pf_flag | output | 1 | Sticky periodic flag |

## Verification
The wave and the flag are registered together. A rising edge of the selected counter bit therefore shows on `sqw_out` and `pf_flag` on the same clock edge, and a clear shows one edge after the strobe. The bench samples on the falling clock edge and stamps every flag event with a count of rising edges. Periods are taken as the difference between two stamps, and the first event after a code change is discarded. The rate-change case counts the whole path: the edges until the old wave falls, then the edges until the new wave rises.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int CNT_W  = 15;
  localparam int CODE_W = 4;
  localparam int NCODES = 1 << CODE_W;
  // codes below ALIAS_TOP reuse the tap of code + ALIAS_OFS
  localparam int ALIAS_TOP = 3;
  localparam int ALIAS_OFS = 7;
  localparam int TAP_OFS   = 2;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic int unsigned tap_index(input int unsigned code);
    int unsigned eff;
    eff = (code < ALIAS_TOP) ? code + ALIAS_OFS : code;
    return eff - TAP_OFS;
  endfunction
endpackage

// File: rtl/prd_counter.sv
module prd_counter
  import prd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output cnt_t cnt_q,
  output cnt_t cnt_nxt
);
  assign cnt_nxt = cnt_q + cnt_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/prd_tap_sel.sv
module prd_tap_sel
  import prd_pkg::*;
(
  input  cnt_t  cnt,
  input  code_t code,
  output logic  tap
);
  logic [NCODES-1:0] taps;

  assign taps[0] = 1'b0;
  for (genvar c = 1; c < NCODES; c++) begin : g_tap
    assign taps[c] = cnt[tap_index(c)];
  end

  assign tap = taps[code];
endmodule

// File: rtl/prd_ctrl.sv
module prd_ctrl
  import prd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t req_code,
  input  logic  old_tap_n,
  input  logic  new_tap_n,
  input  logic  pf_clr,
  output code_t act_code,
  output logic  wave_q,
  output logic  rise,
  output logic  pf_q
);
  logic  act_live, edge_seen, take;
  code_t act_d;
  logic  wave_d, pf_d;

  always_comb begin
    act_live  = (act_code != '0);
    edge_seen = act_live && (old_tap_n != wave_q);
    rise      = act_live && old_tap_n && !wave_q;
    take      = !act_live || edge_seen;
    act_d     = take ? req_code : act_code;
    if (take) wave_d = (req_code != '0) && new_tap_n;
    else      wave_d = old_tap_n;
    pf_d      = rise || (pf_q && !pf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      wave_q   <= 1'b0;
      pf_q     <= 1'b0;
    end else begin
      act_code <= act_d;
      wave_q   <= wave_d;
      pf_q     <= pf_d;
    end
  end
endmodule

// File: rtl/periodic_rate_div.sv
module periodic_rate_div
  import prd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  input  logic       pf_clr,
  output logic       sqw_out,
  output logic       pf_flag
);
  cnt_t  cnt_q, cnt_nxt;
  code_t act_code;
  logic  old_tap_n, new_tap_n, wave_q, rise;

  prd_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  prd_tap_sel u_tap_old (
    .cnt  (cnt_nxt),
    .code (act_code),
    .tap  (old_tap_n)
  );

  prd_tap_sel u_tap_new (
    .cnt  (cnt_nxt),
    .code (rate_sel),
    .tap  (new_tap_n)
  );

  prd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_code  (rate_sel),
    .old_tap_n (old_tap_n),
    .new_tap_n (new_tap_n),
    .pf_clr    (pf_clr),
    .act_code  (act_code),
    .wave_q    (wave_q),
    .rise      (rise),
    .pf_q      (pf_flag)
  );

  assign sqw_out = wave_q && sqw_en;
endmodule

// File: rtl/prd_checker.sv
module prd_checker
  import prd_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  pf_clr,
  input logic  pf_flag,
  input logic  wave_q,
  input logic  rise,
  input code_t act_code,
  input cnt_t  cnt_q
);
  assert_flag_needs_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_flag) |-> ($past(act_code) != '0));

  assert_flag_with_wave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_flag) |-> wave_q);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_flag && !pf_clr) |=> pf_flag);

  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_clr && !rise) |=> !pf_flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pf_flag);

  assert_counter_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt_q == cnt_t'($past(cnt_q) + cnt_t'(1))));
endmodule

bind periodic_rate_div prd_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pf_clr   (pf_clr),
  .pf_flag  (pf_flag),
  .wave_q   (wave_q),
  .rise     (rise),
  .act_code (act_code),
  .cnt_q    (cnt_q)
);

// File: tb/periodic_rate_div_tb_top.sv
module periodic_rate_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b1;
  logic       pf_clr = 1'b0;
  logic       sqw_out, pf_flag;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  periodic_rate_div dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .sqw_en(sqw_en), .pf_clr(pf_clr),
    .sqw_out(sqw_out), .pf_flag(pf_flag)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint period_of(input int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return longint'(1) << (code - 1);
  endfunction

  // pulse a clear, then wait until the flag is seen high; returns edge count
  task automatic wait_rise(output longint t);
    pf_clr = 1'b1;
    @(negedge clk);
    pf_clr = 1'b0;
    for (int n = 0; n < 40000 && !pf_flag; n++) @(negedge clk);
    if (!pf_flag) check(1'b0, "timeout", 0, 1);
    t = cyc;
  endtask

  task automatic t_reset();
    check(sqw_out == 1'b0, "R10 sqw in reset", sqw_out, 0);
    check(pf_flag == 1'b0, "R10 flag in reset", pf_flag, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sqw_out == 1'b0, "R10 sqw after reset", sqw_out, 0);
    check(pf_flag == 1'b0, "R10 flag after reset", pf_flag, 0);
  endtask

  task automatic t_period(input int code, input string req);
    longint t0, t1, t2;
    rate_sel = 4'(code);
    wait_rise(t0);
    wait_rise(t1);
    wait_rise(t2);
    check((t2 - t1) == period_of(code), req, t2 - t1, period_of(code));
  endtask

  task automatic t_duty();
    longint t0;
    int hi, lo;
    sqw_en = 1'b1;
    rate_sel = 4'd4;
    wait_rise(t0);
    wait_rise(t0);
    check(sqw_out == 1'b1, "R5 wave high with flag", sqw_out, 1);
    hi = 1;
    lo = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (!sqw_out) break;
      hi++;
    end
    for (int n = 0; n < 20; n++) begin
      if (sqw_out) break;
      lo++;
      @(negedge clk);
    end
    check(hi == 4, "R5 high half", hi, 4);
    check(lo == 4, "R5 low half", lo, 4);
  endtask

  task automatic t_gate();
    longint t0;
    int seen;
    rate_sel = 4'd3;
    sqw_en = 1'b0;
    seen = 0;
    repeat (8) @(negedge clk);
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      if (sqw_out) seen++;
    end
    check(seen == 0, "R6 pin gated", seen, 0);
    wait_rise(t0);
    check(pf_flag == 1'b1, "R6 flag runs while gated", pf_flag, 1);
    sqw_en = 1'b1;
  endtask

  task automatic t_sticky();
    longint t0;
    int drops;
    rate_sel = 4'd12;
    wait_rise(t0);
    wait_rise(t0);
    drops = 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (!pf_flag) drops++;
    end
    check(drops == 0, "R7 flag holds", drops, 0);
    pf_clr = 1'b1;
    @(negedge clk);
    pf_clr = 1'b0;
    check(pf_flag == 1'b0, "R7 flag cleared", pf_flag, 0);
  endtask

  task automatic t_set_wins();
    int highs;
    rate_sel = 4'd3;
    repeat (4200) @(negedge clk);
    pf_clr = 1'b1;
    @(negedge clk);
    highs = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (pf_flag) highs++;
    end
    pf_clr = 1'b0;
    check(highs == 10, "R8 one-cycle flags under held clear", highs, 10);
  endtask

  task automatic t_quiet();
    int seen;
    rate_sel = 4'd0;
    repeat (10) @(negedge clk);
    pf_clr = 1'b1;
    @(negedge clk);
    pf_clr = 1'b0;
    seen = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (sqw_out || pf_flag) seen++;
    end
    check(seen == 0, "R1 code zero silent", seen, 0);
  endtask

  task automatic t_switch();
    longint t0, t1;
    rate_sel = 4'd15;
    wait_rise(t0);
    wait_rise(t0);
    rate_sel = 4'd3;
    wait_rise(t1);
    check((t1 - t0) == 8194, "R9 switch at next old edge", t1 - t0, 8194);
  endtask

  initial begin
    t_reset();
    t_quiet();
    for (int c = 3; c <= 7; c++) t_period(c, "R2 period");
    for (int c = 8; c <= 14; c++) t_period(c, "R3 period");
    t_period(1, "R4 alias of code 8");
    t_period(2, "R4 alias of code 9");
    t_duty();
    t_gate();
    t_sticky();
    t_set_wins();
    t_quiet();
    t_switch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 195000);
    check(1'b0, "watchdog", cyc, 195000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule